// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block sits behind a bit-level demodulator and turns a stream of already decoded bits into HDLC octets. A bit is offered on `bit_in` together with the one-cycle strobe `bit_vld`. Every bit goes into an eight-bit history, so the block can watch for an opening or closing flag, for a run of seven ones that aborts the frame, and for the zero that a transmitter inserts after five ones. Bits that carry data are gathered into an octet, least significant bit first. Each finished octet is written to a downstream byte FIFO.

The output is one byte stream that carries both data and framing. Every detected flag is written as the byte 0x7E. A data octet whose value collides with one of the three control codes (flag 0x7E, abort 0x7F, escape 0x1B) is written with the escape byte 0x1B in front of it. This lets a consumer tell frame boundaries apart from payload. The FIFO reports `out_full`. A write attempted while it is high is dropped, and the block stops receiving until the next flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A bit is taken only in a cycle where `bit_vld` is high. It enters an eight-bit history at bit 0, and the older bits move up by one place.
- R2: When the history equals 0x7E, the block writes 0x7E in the next cycle. It also becomes armed and clears both its bit count and the partial octet.
- R3: When the history is not 0x7E and its low seven bits are all ones, the block becomes disarmed.
- R4: While disarmed, the only bytes the block writes are flags. Data bits change no state apart from the history.
- R5: While armed, a bit that leaves the low six history bits at 111110 is a stuffed zero. It is discarded and does not count toward the octet.
- R6: While armed, every other bit enters the octet at bit 7 as the octet shifts right, so the first bit received ends up in bit 0. On the eighth such bit the octet is written in the cycle after that bit's strobe.
- R7: A finished octet equal to 0x7E, 0x7F or 0x1B is written as 0x1B in the cycle after the strobe, followed by the octet itself in the next cycle.
- R8: In a cycle where a write is due and `out_full` is high, `out_wr` stays low and the byte is lost. The block is then disarmed, and this also applies when the lost byte is a flag.
- R9: After reset the block is disarmed, its history is zero and `out_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a new decoded bit; never high on two consecutive cycles |
| bit_in | input | 1 | Decoded bit value |
| out_full | input | 1 | Downstream FIFO cannot take a byte this cycle |
| out_wr | output | 1 | Single-cycle write strobe to the FIFO |
| out_data | output | 8 | Byte written when `out_wr` is high |

## Verification
The assertions take for granted that `bit_vld` is never high on two consecutive cycles. Under that rule the escape byte and its data byte leave the output stage before the next octet can be queued. The stimulus offers one bit and then idles for two cycles, so this spacing holds everywhere. `out_full` is driven only in the two cycles after a strobe, when a write may be due. Both directed frames and random bit streams run against a bench model that keeps its own history, armed state and octet.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int OCT_W     = 8;
    localparam int CNT_W     = $clog2(OCT_W);
    localparam int ABORT_RUN = OCT_W - 1;
    localparam int STUFF_W   = OCT_W - 2;

    typedef logic [OCT_W-1:0] octet_t;

    localparam octet_t FLAG_C  = 8'h7E;
    localparam octet_t ABORT_C = 8'h7F;
    localparam octet_t ESC_C   = 8'h1B;
    localparam logic [STUFF_W-1:0] STUFF_PAT = {{(STUFF_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic flag;
        logic abort;
        logic stuff;
    } pat_t;

    typedef struct packed {
        logic   vld;
        logic   pfx;
        octet_t data;
    } slot_t;

    function automatic logic is_ctrl(input octet_t b);
        return (b == FLAG_C) || (b == ABORT_C) || (b == ESC_C);
    endfunction
endpackage

// File: rtl/hdlc_rx_hist.sv
module hdlc_rx_hist import hdlc_rx_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output pat_t pat
);
    octet_t hist;
    octet_t hist_nxt;

    assign hist_nxt = {hist[OCT_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (bit_vld)
            hist <= hist_nxt;
    end

    always_comb begin
        pat.flag  = bit_vld && (hist_nxt == FLAG_C);
        pat.abort = bit_vld && (&hist_nxt[ABORT_RUN-1:0]);
        pat.stuff = bit_vld && (hist_nxt[STUFF_W-1:0] == STUFF_PAT);
    end

    // R1: history only moves on a strobe
    p_hist_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(hist));
endmodule

// File: rtl/hdlc_rx_octet.sv
module hdlc_rx_octet import hdlc_rx_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   shift,
    input  logic   bit_in,
    output logic   done,
    output octet_t byte_out
);
    octet_t             acc;
    logic [CNT_W-1:0]   cnt;
    octet_t             acc_nxt;

    assign acc_nxt  = {bit_in, acc[OCT_W-1:1]};
    assign done     = shift && (cnt == CNT_W'(OCT_W-1));
    assign byte_out = acc_nxt;

    always_ff @(posedge clk) begin
        if (rst || clr || done) begin
            acc <= '0;
            cnt <= '0;
        end else if (shift) begin
            acc <= acc_nxt;
            cnt <= cnt + 1'b1;
        end
    end

    // R5: a bit that is not shifted leaves the count untouched
    p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(cnt));
    // R2: clearing resets the partial octet
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && acc == '0));
endmodule

// File: rtl/hdlc_rx_emit.sv
module hdlc_rx_emit import hdlc_rx_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   put,
    input  octet_t put_byte,
    input  logic   put_esc,
    input  logic   out_full,
    output logic   out_wr,
    output octet_t out_data,
    output logic   fail
);
    slot_t s0;
    slot_t s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0 <= '0;
            s1 <= '0;
        end else if (put) begin
            s0 <= '{vld: 1'b1, pfx: put_esc, data: (put_esc ? ESC_C : put_byte)};
            s1 <= '{vld: put_esc, pfx: 1'b0, data: put_byte};
        end else begin
            s0 <= s1;
            s1 <= '0;
        end
    end

    assign out_wr   = s0.vld && !out_full;
    assign out_data = s0.data;
    assign fail     = s0.vld && out_full;

    // R7: an escape prefix is followed at once by a control-code data byte
    p_esc_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (s0.vld && s0.pfx) |=> (s0.vld && !s0.pfx && is_ctrl(s0.data)));
    // R7: strobe spacing guarantees the second slot is free on a new put
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (rst)
        put |-> !s1.vld);
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer import hdlc_rx_pkg::*; (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_vld,
    input  logic         bit_in,
    input  logic         out_full,
    output logic         out_wr,
    output logic [7:0]   out_data
);
    pat_t   pat;
    logic   armed;
    logic   armed_now;
    logic   fail;
    logic   oct_shift;
    logic   oct_done;
    octet_t oct_byte;
    logic   put;
    octet_t put_byte;
    logic   put_esc;
    octet_t emit_data;

    hdlc_rx_hist u_hist (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .pat     (pat)
    );

    assign armed_now = armed && !fail;
    assign oct_shift = bit_vld && armed_now && !pat.flag && !pat.abort && !pat.stuff;

    hdlc_rx_octet u_octet (
        .clk      (clk),
        .rst      (rst),
        .clr      (pat.flag),
        .shift    (oct_shift),
        .bit_in   (bit_in),
        .done     (oct_done),
        .byte_out (oct_byte)
    );

    assign put      = pat.flag || oct_done;
    assign put_byte = pat.flag ? FLAG_C : oct_byte;
    assign put_esc  = !pat.flag && is_ctrl(oct_byte);

    hdlc_rx_emit u_emit (
        .clk      (clk),
        .rst      (rst),
        .put      (put),
        .put_byte (put_byte),
        .put_esc  (put_esc),
        .out_full (out_full),
        .out_wr   (out_wr),
        .out_data (emit_data),
        .fail     (fail)
    );

    assign out_data = emit_data;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (pat.flag)
            armed <= 1'b1;
        else
            armed <= armed_now && !pat.abort;
    end

    // R1: input rule, strobes are never adjacent
    p_strobe_gap_r1: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld);
    // R2: a flag arms reception
    p_flag_arms_r2: assert property (@(posedge clk) disable iff (rst)
        pat.flag |=> armed);
    // R3: seven ones disarm reception
    p_abort_disarm_r3: assert property (@(posedge clk) disable iff (rst)
        (pat.abort && !pat.flag) |=> !armed);
    // R4: disarmed data bits produce no write
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !armed && !pat.flag && !fail) |=> !out_wr);
    // R8: a lost write disarms reception
    p_full_disarm_r8: assert property (@(posedge clk) disable iff (rst)
        (fail && !pat.flag) |=> !armed);
    // R8: nothing is written while the FIFO is full
    p_no_write_full_r8: assert property (@(posedge clk) disable iff (rst)
        out_full |-> !out_wr);
endmodule

// File: tb/sim_hdlc_rx_deframer.sv
module sim_hdlc_rx_deframer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       out_full = 1'b0;
    logic       out_wr;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int full_mode = 0;   // 0 never, 1 random, 2 always
    int ones = 0;

    logic [7:0] m_hist;
    logic       m_armed;
    logic [7:0] m_acc;
    int         m_cnt;

    always #2.5 clk = ~clk;

    hdlc_rx_deframer u0 (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .out_full(out_full), .out_wr(out_wr), .out_data(out_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic ctrl_code(input logic [7:0] v);
        return v == 8'h7E || v == 8'h7F || v == 8'h1B;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual wr/data %h expected %h", tag, act, exp);
        end
    endtask

    // Bench model of one strobe: returns the bytes that should be written
    task automatic model_bit(input logic b, output int n, output logic [7:0] e0, output logic [7:0] e1);
        n = 0; e0 = 8'h00; e1 = 8'h00;
        m_hist = {m_hist[6:0], b};
        if (m_hist == 8'h7E) begin
            m_armed = 1'b1; m_cnt = 0; m_acc = 8'h00;
            n = 1; e0 = 8'h7E;
        end else begin
            if (m_hist[6:0] == 7'h7F) m_armed = 1'b0;
            if (m_armed && m_hist[5:0] != 6'b111110) begin
                m_acc = {b, m_acc[7:1]};
                m_cnt = m_cnt + 1;
                if (m_cnt == 8) begin
                    if (ctrl_code(m_acc)) begin n = 2; e0 = 8'h1B; e1 = m_acc; end
                    else begin n = 1; e0 = m_acc; end
                    m_cnt = 0; m_acc = 8'h00;
                end
            end
        end
    endtask

    function automatic logic pick_full();
        if (full_mode == 2) return 1'b1;
        if (full_mode == 1) return ($urandom_range(0, 9) == 0);
        return 1'b0;
    endfunction

    task automatic window(input int idx, input int n, input logic [7:0] e, input logic flagged);
        string tag;
        if (idx < n) begin
            if (out_full) begin
                check(!out_wr, "R8", {out_wr, out_data}, {1'b0, out_data});
                m_armed = 1'b0;
            end else begin
                tag = flagged ? "R1 R2" : ((n == 2) ? "R7" : "R5 R6");
                check(out_wr && out_data == e, tag, {out_wr, out_data}, {1'b1, e});
            end
        end else begin
            tag = m_armed ? "R5 R6" : "R3 R4";
            check(!out_wr, tag, {out_wr, out_data}, 9'h000);
        end
    endtask

    task automatic send_bit(input logic b);
        int n; logic [7:0] e0; logic [7:0] e1; logic flagged;
        @(negedge clk);
        bit_vld = 1'b1; bit_in = b; out_full = 1'b0;
        model_bit(b, n, e0, e1);
        flagged = (n == 1 && e0 == 8'h7E && m_hist == 8'h7E);
        @(negedge clk);
        bit_vld = 1'b0; out_full = pick_full();
        #1 window(0, n, e0, flagged);
        @(negedge clk);
        out_full = pick_full();
        #1 window(1, n, e1, flagged);
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit(i != 0 && i != 7);
        ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            ones = v[i] ? ones + 1 : 0;
            if (ones == 5) begin send_bit(1'b0); ones = 0; end
        end
    endtask

    task automatic send_abort();
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        ones = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_hist = 8'h00; m_armed = 1'b0; m_acc = 8'h00; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_wr, "R9", {out_wr, out_data}, 9'h000);

        // R4: data before any flag is ignored
        send_byte(8'h55); send_byte(8'hA3);
        // R2 R6 R7 R5: a frame with ordinary, escaped and stuffed bytes
        send_flag();
        send_byte(8'h12); send_byte(8'h7E); send_byte(8'hFF);
        send_byte(8'h1B); send_byte(8'h7F); send_byte(8'hF8);
        send_flag();
        // R3: abort, then data is ignored until the next flag
        send_byte(8'h3C); send_abort(); send_byte(8'h42);
        send_flag(); send_byte(8'h99);
        // R8: full during a data write disarms
        full_mode = 2; send_byte(8'h21); full_mode = 0;
        send_byte(8'h44);
        // R8: a flag lost to a full FIFO leaves the block disarmed
        full_mode = 2; send_flag(); full_mode = 0;
        send_byte(8'h5A);
        send_flag(); send_byte(8'h01);

        // Random frames and raw bit streams
        for (int it = 0; it < 250; it++) begin
            int sel;
            full_mode = ($urandom_range(0, 3) == 0) ? 1 : 0;
            sel = $urandom_range(0, 9);
            if (sel < 2) send_flag();
            else if (sel == 2) send_abort();
            else if (sel < 5) begin
                for (int k = 0; k < 6; k++) send_bit($urandom_range(0, 1));
            end else begin
                int pick = $urandom_range(0, 5);
                logic [7:0] v;
                v = (pick == 0) ? 8'h7E : (pick == 1) ? 8'h1B : (pick == 2) ? 8'h7F : 8'($urandom);
                send_byte(v);
            end
        end
        full_mode = 0;
        send_flag(); send_byte(8'hC3); send_flag();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule